// File: doc/BRIEF.md
# Real-Time Clock Interrupt Flag and Request Logic

This block gathers the three interrupt events of a real-time clock (periodic tick, alarm match and end of time update) into one status byte and drives a shared interrupt request line. Each event arrives as a one-cycle pulse from the timekeeping logic. The event latches a sticky flag whether or not its source is enabled, so software can poll the flag instead of taking the interrupt.

The request line is open-drain and active-low. It is modelled here as a drive-low enable, `irq_drive_low`. The line is pulled down while at least one source has both its flag and its enable set. The status byte carries the three flags and a summary bit that mirrors the request. A read of the status byte clears every flag that was read as set. An event that lands in the cycle of the read survives, so it is seen on the next read.

An active-low reset pin is also provided. While it is low, the flags are held at zero, the enables are masked, the request is released and status reads are blocked. A synchronous active-high system reset clears the flags as well.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: A one-cycle event pulse sets its flag on the next clock edge, whatever the state of the matching enable.
- R2: `irq_drive_low` is 1 exactly when the reset pin is high and at least one source has both its flag and its enable set; otherwise it is 0 (line released).
- R3: Bit 7 of `stat_rdata` (the summary bit) always equals `irq_drive_low`.
- R4: Setting an enable while its flag is already 1 asserts `irq_drive_low` in the same cycle, with no clock edge in between.
- R5: A `stat_rd` pulse clears, on that clock edge, every flag that was 1, and with them the summary bit.
- R6: An event pulse in the same cycle as `stat_rd` leaves its flag set after the edge.
- R7: Status byte layout: bit 6 is the periodic flag, bit 5 the alarm flag, bit 4 the update-ended flag, bit 7 the summary bit, and bits 3 to 0 always read as 0.
- R8: While `rst_pin_n` is low, `irq_drive_low` and `stat_rdata` are 0 at once. Flags are cleared on the next edge, and events and reads do not change them.
- R9: A high `rst` clears all flags on the next clock edge.
- R10: With no event, no read and the reset pin high, the flags keep their value from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| rst_pin_n | input | 1 | Active-low reset pin; masks enables and blocks access |
| evt_periodic | input | 1 | One-cycle periodic tick event |
| evt_alarm | input | 1 | One-cycle alarm match event |
| evt_update | input | 1 | One-cycle update-ended event |
| en_periodic | input | 1 | Periodic interrupt enable |
| en_alarm | input | 1 | Alarm interrupt enable |
| en_update | input | 1 | Update-ended interrupt enable |
| stat_rd | input | 1 | One-cycle pulse marking the end of a status read |
| stat_rdata | output | 8 | Status byte: summary, three flags, zero nibble |
| irq_drive_low | output | 1 | 1 = pull the open-drain request line low |

## Verification
The read-and-clear of the status byte and the arrival of a new event can fall in the same cycle. The bench forces this by raising `stat_rd` together with one or more event pulses, both when the flags are already set and when they are clear. It then checks that exactly the coinciding sources are set after the edge and that everything else is cleared. A second overlap, an enable rising while a flag is already pending, is judged without letting a clock edge pass.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    localparam int NSRC     = 3;
    localparam int PAD_W    = 4;
    localparam int STAT_W   = 1 + NSRC + PAD_W;

    // vector index of each source; index i lands at status bit PAD_W+i
    localparam int SRC_UPDATE   = 0;
    localparam int SRC_ALARM    = 1;
    localparam int SRC_PERIODIC = 2;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef struct packed {
        logic             summary;
        src_vec_t         flags;
        logic [PAD_W-1:0] pad;
    } stat_byte_t;

    function automatic stat_byte_t pack_status(input logic summary, input src_vec_t flags);
        stat_byte_t s;
        s.summary = summary;
        s.flags   = flags;
        s.pad     = '0;
        return s;
    endfunction

endpackage

// File: rtl/irq_flag_cell.sv
module irq_flag_cell (
    input  logic clk,
    input  logic rst,
    input  logic live,
    input  logic evt,
    input  logic clr,
    output logic q
);

    always_ff @(posedge clk) begin
        if (rst || !live) begin
            q <= 1'b0;
        end else if (evt) begin
            q <= 1'b1;          // a new event beats a concurrent clear
        end else if (clr) begin
            q <= 1'b0;
        end
    end

    p_set_r1: assert property (@(posedge clk) disable iff (rst)
        (live && evt) |=> q);

    p_evt_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (live && evt && clr) |=> q);

    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (live && clr && !evt) |=> !q);

    p_pin_r8: assert property (@(posedge clk) disable iff (rst)
        !live |=> !q);

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (live && !evt && !clr) |=> $stable(q));

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import rtc_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     live,
    input  src_vec_t evt,
    input  logic     rd_done,
    output src_vec_t flags
);

    for (genvar i = 0; i < NSRC; i++) begin : g_cell
        logic clr_i;
        // only bits that were read as set are cleared
        assign clr_i = rd_done & flags[i];
        irq_flag_cell u_cell (
            .clk  (clk),
            .rst  (rst),
            .live (live),
            .evt  (evt[i]),
            .clr  (clr_i),
            .q    (flags[i])
        );
    end

endmodule

// File: rtl/irq_req_merge.sv
module irq_req_merge
    import rtc_irq_pkg::*;
(
    input  logic     live,
    input  src_vec_t flags,
    input  src_vec_t en,
    output logic     req
);

    src_vec_t armed;

    always_comb begin
        armed = flags & (live ? en : '0);
        req   = |armed;
    end

endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
    import rtc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rst_pin_n,
    input  logic              evt_periodic,
    input  logic              evt_alarm,
    input  logic              evt_update,
    input  logic              en_periodic,
    input  logic              en_alarm,
    input  logic              en_update,
    input  logic              stat_rd,
    output logic [STAT_W-1:0] stat_rdata,
    output logic              irq_drive_low
);

    src_vec_t   evt_v;
    src_vec_t   en_v;
    src_vec_t   flags;
    logic       rd_ok;
    logic       req;
    stat_byte_t stat;

    always_comb begin
        evt_v               = '0;
        evt_v[SRC_UPDATE]   = evt_update;
        evt_v[SRC_ALARM]    = evt_alarm;
        evt_v[SRC_PERIODIC] = evt_periodic;
        en_v                = '0;
        en_v[SRC_UPDATE]    = en_update;
        en_v[SRC_ALARM]     = en_alarm;
        en_v[SRC_PERIODIC]  = en_periodic;
    end

    assign rd_ok = stat_rd & rst_pin_n;

    irq_flag_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .live    (rst_pin_n),
        .evt     (evt_v),
        .rd_done (rd_ok),
        .flags   (flags)
    );

    irq_req_merge u_merge (
        .live  (rst_pin_n),
        .flags (flags),
        .en    (en_v),
        .req   (req)
    );

    always_comb begin
        stat = rst_pin_n ? pack_status(req, flags) : '0;
    end

    assign stat_rdata    = stat;
    assign irq_drive_low = req;

    p_release_r8: assert property (@(posedge clk) disable iff (rst)
        !rst_pin_n |-> (!irq_drive_low && stat_rdata == '0));

    p_read_drops_req_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_ok && !evt_periodic && !evt_alarm && !evt_update) |=> !irq_drive_low);

endmodule

// File: tb/tb_rtc_irq_ctrl.sv
module tb_rtc_irq_ctrl;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst, rst_pin_n, stat_rd;
    logic [2:0] evt, en;       // [2]=periodic [1]=alarm [0]=update
    logic [7:0] stat_rdata;
    logic       irq_drive_low;
    int         errors = 0;
    int         checks = 0;
    bit         finished = 0;

    always #(CLK_P/2) clk = ~clk;

    rtc_irq_ctrl dut (
        .clk           (clk),
        .rst           (rst),
        .rst_pin_n     (rst_pin_n),
        .evt_periodic  (evt[2]),
        .evt_alarm     (evt[1]),
        .evt_update    (evt[0]),
        .en_periodic   (en[2]),
        .en_alarm      (en[1]),
        .en_update     (en[0]),
        .stat_rd       (stat_rd),
        .stat_rdata    (stat_rdata),
        .irq_drive_low (irq_drive_low)
    );

    function automatic logic [7:0] exp_byte(input logic [2:0] f, input logic [2:0] e);
        return {|(f & e), f, 4'b0000};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #(CLK_P/4);
    endtask

    task automatic load(input logic [2:0] f);
        evt = f; cyc(); evt = '0;
    endtask

    task automatic do_read();
        stat_rd = 1'b1; cyc(); stat_rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; rst_pin_n = 1'b1; stat_rd = 1'b0; evt = '0; en = '0;
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        chk("R9 reset state", stat_rdata, 8'h00);
        chk("R2 reset release", {7'b0, irq_drive_low}, 8'h00);

        // sweep every flag pattern against every enable pattern
        for (int f = 0; f < 8; f++) begin
            for (int e = 0; e < 8; e++) begin
                en = '0;
                load(f[2:0]);
                chk("R1 R7 flag set with enables off", stat_rdata, exp_byte(f[2:0], 3'b000));
                en = e[2:0];
                #1;
                chk("R4 R7 immediate request", stat_rdata, exp_byte(f[2:0], e[2:0]));
                chk("R2 R3 drive equals summary", {7'b0, irq_drive_low}, {7'b0, |(f[2:0] & e[2:0])});
                do_read();
                chk("R5 read clears", {stat_rdata[7:1], irq_drive_low}, 8'h00);
            end
        end

        // event coinciding with the read: only coinciding sources survive
        for (int f = 0; f < 8; f++) begin
            for (int v = 0; v < 8; v++) begin
                en = 3'b111;
                load(f[2:0]);
                evt = v[2:0]; stat_rd = 1'b1; cyc(); evt = '0; stat_rd = 1'b0;
                chk("R6 event wins over clear", stat_rdata, exp_byte(v[2:0], 3'b111));
                do_read();
            end
        end

        // hold with no activity
        en = 3'b000;
        load(3'b101);
        repeat (5) begin
            cyc();
            chk("R10 flags hold", stat_rdata, 8'h50);
        end

        // reset pin behaviour
        en = 3'b111;
        #1;
        chk("R2 pending request", {7'b0, irq_drive_low}, 8'h01);
        rst_pin_n = 1'b0;
        #1;
        chk("R8 immediate release", {7'b0, irq_drive_low}, 8'h00);
        chk("R8 access blocked", stat_rdata, 8'h00);
        evt = 3'b111; stat_rd = 1'b1; cyc(); cyc(); evt = '0; stat_rd = 1'b0;
        rst_pin_n = 1'b1;
        #1;
        chk("R8 flags cleared and events ignored", stat_rdata, 8'h00);
        chk("R8 no request after pin", {7'b0, irq_drive_low}, 8'h00);

        // system reset clears flags
        load(3'b011);
        chk("R1 flags before reset", stat_rdata, 8'hB0);
        rst = 1'b1; cyc(); rst = 1'b0;
        chk("R9 reset clears flags", stat_rdata, 8'h00);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule